// File: doc/BRIEF.md
# Widening Half-to-Single Multiply-Accumulate Lanes

This block is a SIMD arithmetic datapath that multiplies packed half-precision elements by one half-precision scalar and adds each product into a single-precision accumulator lane. The scalar is picked by an index out of a packed scalar source and is broadcast to every lane. Each lane forms the exact product of its two half-precision factors, with no intermediate rounding. It then adds the product to the 32-bit accumulator and rounds once to nearest-even.

A width control selects between two layouts. In the narrow layout, two elements from a 32-bit vector source update one 64-bit accumulator word. In the wide layout, four elements from a 64-bit source update two 64-bit words. A subtract control negates the vector elements before the multiply. Results and the exception flags are registered together and appear one cycle after a valid request. The flags are ORed across the active lanes.

Top module: `fp16_widen_mac`

## Requirements
- R1: Results and flags load into the output registers on a clock edge where `in_valid` is high, and `out_valid` follows `in_valid` one cycle later. The outputs hold their value while `in_valid` is low. Reset clears `out_valid`, `acc_out` and all flags to zero.
- R2: When `wide`=0, half element 0 is `vec_src[15:0]` and updates accumulator lane 0 at bits [31:0]. Half element 1 is `vec_src[31:16]` and updates lane 1 at bits [63:32]. `acc_out[127:64]` equals `acc_in[127:64]`, and `vec_src[63:32]` has no effect.
- R3: When `wide`=1, half element k is taken from `vec_src[16k+15:16k]` and updates accumulator lane k at bits [32k+31:32k], for k = 0 to 3. Accumulator word r therefore takes elements 2r and 2r+1.
- R4: The scalar multiplier is element s of the scalar source, at bits [16s+15:16s]. When `wide`=1, s is `idx`. When `wide`=0, s is `idx[0]`, and both `idx[1]` and `scl_src[63:32]` are ignored. The same scalar is used in every lane.
- R5: With `sub`=1 each lane computes acc + (−a)·b. Only the vector element is negated, and this includes the sign of a zero product.
- R6: The half×half product is never rounded before the add. For example, 0x3C01·0x3C01 + 0 gives 0x3F804008, and 1.0 − 2^-24 gives 0x3F7FFFFF exactly.
- R7: The single rounding step is round-to-nearest-even. A tie rounds to the even significand: 1.0 + 2^-24 gives 0x3F800000, and 0x3F800001 + 2^-24 gives 0x3F800002.
- R8: Subnormal half inputs (exponent field 0) and subnormal single accumulators are used at their exact value. For example, 0x0001·0x0001 + 0 gives 0x27800000.
- R9: A NaN result is always 0x7FC00000. It is produced by any NaN input, by infinity×zero, and by an infinite product added to an infinity of the opposite sign. A NaN is signaling when the most significant fraction bit is 0. `flg_invalid` is set for infinity×zero, for the opposite-infinity sum, and for a signaling NaN input. A quiet NaN input alone leaves it clear. Any other infinite product or accumulator gives a correctly signed infinity with no flag.
- R10: An exact zero sum of operands with opposite signs gives +0. A sum of two zeros that are both negative gives −0.
- R11: `flg_inexact` is set when rounding discards nonzero bits. `flg_overflow` and `flg_underflow` each imply `flg_inexact`. The largest finite accumulator plus the largest half product stays finite with `flg_overflow` clear. Lanes that the width mode leaves inactive contribute no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid; results load at this edge |
| wide | input | 1 | 1: four lanes from 64-bit sources; 0: two lanes from 32-bit sources |
| sub | input | 1 | Negate vector elements before the multiply |
| idx | input | 2 | Scalar element index |
| vec_src | input | 64 | Packed half-precision vector elements |
| scl_src | input | 64 | Packed half-precision scalar source |
| acc_in | input | 128 | Four single-precision accumulator lanes (two 64-bit words) |
| out_valid | output | 1 | Registered result valid |
| acc_out | output | 128 | Updated accumulator lanes |
| flg_invalid | output | 1 | Invalid-operation flag |
| flg_overflow | output | 1 | Overflow flag |
| flg_underflow | output | 1 | Underflow flag (tiny before rounding and inexact) |
| flg_inexact | output | 1 | Inexact flag |

## Verification
The assertions check, on every cycle, the properties that do not depend on arithmetic values. These are the one-cycle valid latency, the holding of the outputs between requests, and the pass-through of the upper accumulator word in narrow mode. They also check that a raised invalid flag comes with a default NaN in some lane, and that overflow or underflow never appears without inexact. The arithmetic itself can only be shown by the bench's scenarios. These cover the single rounding of the unrounded product, ties to even, cancellation just below one, subnormal factors, the infinity and NaN rules, and signed zeros. Lane-to-element mapping and index selection are also checked there, using distinct values in each lane and decoy NaN values in the positions that must be ignored.

// File: rtl/fp16_widen_mac.sv
module fp16_widen_mac (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         wide,
  input  logic         sub,
  input  logic [1:0]   idx,
  input  logic [63:0]  vec_src,
  input  logic [63:0]  scl_src,
  input  logic [127:0] acc_in,
  output logic         out_valid,
  output logic [127:0] acc_out,
  output logic         flg_invalid,
  output logic         flg_overflow,
  output logic         flg_underflow,
  output logic         flg_inexact
);
  localparam int LANES  = 4;
  localparam int NLANES = 2;
  localparam int HW     = 16;
  localparam int SW     = 32;

  // returns {invalid, overflow, underflow, inexact, result}
  function automatic logic [35:0] mac_lane(input logic [15:0] a, input logic [15:0] b,
                                           input logic [31:0] c, input logic neg);
    logic sa, sb, sc, sp, s_big, s_sml, p_big, inv, ovf, unf, inx, g, st, tiny;
    logic a_nan, b_nan, c_nan, a_inf, b_inf, c_inf, a_zero, b_zero, c_zero;
    logic snan, mul_bad, add_bad, p_inf;
    logic [10:0]  ma, mb;
    logic [21:0]  mp;
    logic [23:0]  mc;
    logic [47:0]  np, nc, n_big, n_sml;
    logic [127:0] big_w, sml_w, sum_w, tmp;
    logic [24:0]  m;
    logic [63:0]  tot;
    logic [31:0]  res;
    int xp, xc, yp, yc, y_big, d, msb, lead, eun, lsb, ebase;

    sa = a[15] ^ neg; sb = b[15]; sc = c[31]; sp = sa ^ sb;
    a_nan  = (a[14:10] == 5'h1F) && (a[9:0] != 10'h0);
    b_nan  = (b[14:10] == 5'h1F) && (b[9:0] != 10'h0);
    c_nan  = (c[30:23] == 8'hFF) && (c[22:0] != 23'h0);
    a_inf  = (a[14:10] == 5'h1F) && (a[9:0] == 10'h0);
    b_inf  = (b[14:10] == 5'h1F) && (b[9:0] == 10'h0);
    c_inf  = (c[30:23] == 8'hFF) && (c[22:0] == 23'h0);
    a_zero = (a[14:0] == 15'h0);
    b_zero = (b[14:0] == 15'h0);
    c_zero = (c[30:0] == 31'h0);
    snan    = (a_nan && !a[9]) || (b_nan && !b[9]) || (c_nan && !c[22]);
    mul_bad = (a_inf && b_zero) || (b_inf && a_zero);
    p_inf   = a_inf || b_inf;
    add_bad = p_inf && c_inf && (sp != sc) && !a_nan && !b_nan && !mul_bad;
    inv = snan || mul_bad || add_bad;
    ovf = 1'b0; unf = 1'b0; inx = 1'b0;
    res = 32'h0;

    if (a_nan || b_nan || c_nan || mul_bad || add_bad) res = 32'h7FC0_0000;
    else if (p_inf) res = {sp, 8'hFF, 23'h0};
    else if (c_inf) res = c;
    else if (a_zero || b_zero) res = c_zero ? {sp & sc, 31'h0} : c;
    else begin
      ma = {a[14:10] != 5'h0, a[9:0]};
      mb = {b[14:10] != 5'h0, b[9:0]};
      mp = 22'(ma) * 22'(mb);
      xp = ((a[14:10] == 5'h0) ? 1 : int'(a[14:10])) +
           ((b[14:10] == 5'h0) ? 1 : int'(b[14:10])) - 50;
      mc = {c[30:23] != 8'h0, c[22:0]};
      xc = ((c[30:23] == 8'h0) ? 1 : int'(c[30:23])) - 150;

      msb = 0;
      for (int i = 0; i < 22; i++) if (mp[i]) msb = i;
      np = 48'(mp) << (47 - msb);
      yp = xp - (47 - msb);
      msb = 0;
      for (int i = 0; i < 24; i++) if (mc[i]) msb = i;
      nc = 48'(mc) << (47 - msb);
      yc = xc - (47 - msb);

      p_big = c_zero || (yp > yc) || ((yp == yc) && (np >= nc));
      if (p_big) begin
        n_big = np; y_big = yp; s_big = sp; n_sml = nc; s_sml = sc; d = yp - yc;
      end else begin
        n_big = nc; y_big = yc; s_big = sc; n_sml = np; s_sml = sp; d = yc - yp;
      end

      big_w = {2'b0, n_big, 78'h0};
      if (c_zero)       sml_w = '0;
      else if (d > 100) sml_w = 128'd1;
      else              sml_w = {2'b0, n_sml, 78'h0} >> d;
      sum_w = (s_big != s_sml) ? big_w - sml_w : big_w + sml_w;

      if (sum_w == '0) res = 32'h0;
      else begin
        lead = 0;
        for (int i = 0; i < 128; i++) if (sum_w[i]) lead = i;
        eun  = lead + y_big - 78;
        tiny = eun < -126;
        lsb  = tiny ? (-71 - y_big) : (lead - 23);
        if (lsb <= 0) begin
          tmp = sum_w << (-lsb); g = 1'b0; st = 1'b0;
        end else begin
          tmp = sum_w >> lsb;
          g   = sum_w[7'(lsb - 1)];
          st  = |(sum_w & ~({128{1'b1}} << (lsb - 1)));
        end
        m     = tmp[24:0] + 25'(g && (st || tmp[0]));
        ebase = tiny ? 0 : eun + 126;
        tot   = 64'(ebase) * 64'd8388608 + 64'(m);
        inx   = g || st;
        unf   = tiny && inx;
        if (tot >= 64'h7F80_0000) begin
          res = {s_big, 8'hFF, 23'h0}; ovf = 1'b1; inx = 1'b1;
        end else res = {s_big, tot[30:0]};
      end
    end
    return {inv, ovf, unf, inx, res};
  endfunction

  logic [1:0]           sel;
  logic [HW-1:0]        scl_pick;
  logic [LANES*SW-1:0]  nxt;
  logic [LANES*4-1:0]   fl_all;
  logic [3:0]           fl_or;

  assign sel      = wide ? idx : {1'b0, idx[0]};
  assign scl_pick = scl_src[{sel, 4'b0} +: HW];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [35:0] r;
    logic        on;
    assign on = wide || (k < NLANES);
    assign r  = mac_lane(vec_src[HW*k +: HW], scl_pick, acc_in[SW*k +: SW], sub);
    assign nxt[SW*k +: SW] = on ? r[31:0] : acc_in[SW*k +: SW];
    assign fl_all[4*k +: 4] = on ? r[35:32] : 4'h0;
  end

  assign fl_or = fl_all[3:0] | fl_all[7:4] | fl_all[11:8] | fl_all[15:12];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
      {flg_invalid, flg_overflow, flg_underflow, flg_inexact} <= 4'h0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        acc_out <= nxt;
        {flg_invalid, flg_overflow, flg_underflow, flg_inexact} <= fl_or;
      end
    end
  end
endmodule

// File: rtl/fp16_widen_mac_chk.sv
module fp16_widen_mac_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         wide,
  input logic [127:0] acc_in,
  input logic         out_valid,
  input logic [127:0] acc_out,
  input logic         flg_invalid,
  input logic         flg_overflow,
  input logic         flg_underflow,
  input logic         flg_inexact
);
  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R1
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(acc_out));

  // R2
  upper_word_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && !wide) |-> acc_out[127:64] == $past(acc_in[127:64]));

  // R9
  invalid_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flg_invalid) |->
      (acc_out[31:0] == 32'h7FC0_0000) || (acc_out[63:32] == 32'h7FC0_0000) ||
      (acc_out[95:64] == 32'h7FC0_0000) || (acc_out[127:96] == 32'h7FC0_0000));

  // R11
  overflow_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flg_overflow |-> flg_inexact);

  // R11
  underflow_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flg_underflow |-> flg_inexact);
endmodule

bind fp16_widen_mac fp16_widen_mac_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide(wide), .acc_in(acc_in),
  .out_valid(out_valid), .acc_out(acc_out), .flg_invalid(flg_invalid),
  .flg_overflow(flg_overflow), .flg_underflow(flg_underflow), .flg_inexact(flg_inexact)
);

// File: tb/fp16_widen_mac_tb_top.sv
`timescale 1ns/1ps
module fp16_widen_mac_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         wide = 1'b0;
  logic         sub = 1'b0;
  logic [1:0]   idx = 2'b0;
  logic [63:0]  vec_src = '0;
  logic [63:0]  scl_src = '0;
  logic [127:0] acc_in = '0;
  logic         out_valid;
  logic [127:0] acc_out;
  logic         flg_invalid, flg_overflow, flg_underflow, flg_inexact;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fp16_widen_mac dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide(wide), .sub(sub), .idx(idx),
    .vec_src(vec_src), .scl_src(scl_src), .acc_in(acc_in), .out_valid(out_valid),
    .acc_out(acc_out), .flg_invalid(flg_invalid), .flg_overflow(flg_overflow),
    .flg_underflow(flg_underflow), .flg_inexact(flg_inexact)
  );

  // row: {sub, a, b, acc, expected, flags{inv,ovf,unf,inx}}
  localparam int NROW = 21;
  localparam logic [100:0] TBL [NROW] = '{
    {1'b0, 16'h3C01, 16'h3C01, 32'h0000_0000, 32'h3F80_4008, 4'b0000}, // R6 unrounded product
    {1'b0, 16'h0C00, 16'h0C00, 32'h3F80_0000, 32'h3F80_0000, 4'b0001}, // R7 tie to even, stays
    {1'b0, 16'h0C00, 16'h0C00, 32'h3F80_0001, 32'h3F80_0002, 4'b0001}, // R7 tie to even, up
    {1'b0, 16'h0001, 16'h0001, 32'h0000_0000, 32'h2780_0000, 4'b0000}, // R8 subnormal factors
    {1'b0, 16'h0001, 16'h0001, 32'h0000_0001, 32'h2780_0000, 4'b0001}, // R8 subnormal acc, far apart
    {1'b0, 16'h0200, 16'h4000, 32'h0000_0000, 32'h3880_0000, 4'b0000}, // R8 subnormal times normal
    {1'b0, 16'h0000, 16'h3C00, 32'h0000_0001, 32'h0000_0001, 4'b0000}, // R8 subnormal acc kept
    {1'b0, 16'h7BFF, 16'h7BFF, 32'h7F7F_FFFF, 32'h7F7F_FFFF, 4'b0001}, // R11 no overflow at max
    {1'b0, 16'h7C00, 16'h3C00, 32'h3F80_0000, 32'h7F80_0000, 4'b0000}, // R9 infinite product
    {1'b0, 16'h7C00, 16'h0000, 32'h3F80_0000, 32'h7FC0_0000, 4'b1000}, // R9 inf times zero
    {1'b0, 16'h3C00, 16'h7C00, 32'hFF80_0000, 32'h7FC0_0000, 4'b1000}, // R9 inf minus inf
    {1'b0, 16'h7E00, 16'h3C00, 32'h3F80_0000, 32'h7FC0_0000, 4'b0000}, // R9 quiet NaN half
    {1'b0, 16'h7D00, 16'h3C00, 32'h3F80_0000, 32'h7FC0_0000, 4'b1000}, // R9 signaling NaN half
    {1'b0, 16'h3C00, 16'h3C00, 32'h7FA0_0000, 32'h7FC0_0000, 4'b1000}, // R9 signaling NaN acc
    {1'b0, 16'h3C00, 16'h3C00, 32'h7FC1_2345, 32'h7FC0_0000, 4'b0000}, // R9 quiet NaN acc
    {1'b0, 16'h3C00, 16'h3C00, 32'hBF80_0000, 32'h0000_0000, 4'b0000}, // R10 cancel to +0
    {1'b0, 16'h8000, 16'h3C00, 32'h8000_0000, 32'h8000_0000, 4'b0000}, // R10 -0 plus -0
    {1'b1, 16'h0000, 16'h3C00, 32'h8000_0000, 32'h8000_0000, 4'b0000}, // R5 negated zero product
    {1'b1, 16'h3C00, 16'h4000, 32'h4040_0000, 32'h3F80_0000, 4'b0000}, // R5 subtract
    {1'b0, 16'h0400, 16'h0400, 32'h3F80_0000, 32'h3F80_0000, 4'b0001}, // R11 inexact sticky
    {1'b1, 16'h0C00, 16'h0C00, 32'h3F80_0000, 32'h3F7F_FFFF, 4'b0000}  // R6 exact below one
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic w, input logic s, input logic [1:0] ix,
                       input logic [63:0] v, input logic [63:0] sc, input logic [127:0] ac);
    @(negedge clk);
    wide = w; sub = s; idx = ix; vec_src = v; scl_src = sc; acc_in = ac; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [127:0] flags4();
    return 128'({flg_invalid, flg_overflow, flg_underflow, flg_inexact});
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act running exp done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset valid", 128'(out_valid), 128'd0);
    chk("R1 reset acc", acc_out, 128'd0);
    chk("R1 reset flags", flags4(), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table: narrow mode, both lanes identical, decoys in ignored positions (R2, R4, R11)
    for (int i = 0; i < NROW; i++) begin
      logic [100:0] row;
      row = TBL[i];
      issue(1'b0, row[100], 2'b10, {32'hFFFF_FFFF, row[99:84], row[99:84]},
            {32'hFFFF_FFFF, 16'h7E00, row[83:68]},
            {64'hA5A5_5A5A_0F0F_F0F0, row[67:36], row[67:36]});
      chk($sformatf("R1 valid row %0d", i), 128'(out_valid), 128'd1);
      chk($sformatf("R2 lanes row %0d", i), acc_out,
          {64'hA5A5_5A5A_0F0F_F0F0, row[35:4], row[35:4]});
      chk($sformatf("R11 flags row %0d", i), flags4(), 128'(row[3:0]));
    end

    // R3 R4 wide mapping, idx 2 selects 2.0
    issue(1'b1, 1'b0, 2'd2, 64'hBC00_4200_4000_3C00, 64'h4200_4000_3C00_3800,
          {4{32'h3F80_0000}});
    chk("R3 wide add", acc_out, {32'hBF80_0000, 32'h40E0_0000, 32'h40A0_0000, 32'h4040_0000});
    chk("R3 wide flags", flags4(), 128'd0);
    // R5 wide subtract
    issue(1'b1, 1'b1, 2'd2, 64'hBC00_4200_4000_3C00, 64'h4200_4000_3C00_3800,
          {4{32'h3F80_0000}});
    chk("R5 wide sub", acc_out, {32'h4040_0000, 32'hC0A0_0000, 32'hC040_0000, 32'hBF80_0000});
    // R4 wide idx 3 selects 3.0
    issue(1'b1, 1'b0, 2'd3, 64'hBC00_4200_4000_3C00, 64'h4200_4000_3C00_3800,
          {4{32'h3F80_0000}});
    chk("R4 wide idx3", acc_out, {32'hC000_0000, 32'h4120_0000, 32'h40E0_0000, 32'h4080_0000});
    // R4 narrow idx[0]=1 selects element 1 (3.0); upper halves are NaN decoys
    issue(1'b0, 1'b0, 2'b11, 64'hFFFF_FFFF_4000_3C00, 64'hFFFF_FFFF_4200_3800,
          {64'h1234_5678_9ABC_DEF0, 32'h3F80_0000, 32'h3F80_0000});
    chk("R4 narrow idx1", acc_out, {64'h1234_5678_9ABC_DEF0, 32'h40E0_0000, 32'h4080_0000});
    chk("R2 narrow flags", flags4(), 128'd0);
    // R4 narrow idx[1] ignored: idx 2'b10 selects element 0 (0.5)
    issue(1'b0, 1'b0, 2'b10, 64'hFFFF_FFFF_4000_3C00, 64'hFFFF_FFFF_4200_3800,
          {64'h1234_5678_9ABC_DEF0, 32'h3F80_0000, 32'h3F80_0000});
    chk("R4 narrow idx0", acc_out, {64'h1234_5678_9ABC_DEF0, 32'h4000_0000, 32'h3FC0_0000});

    // R1 hold while idle
    @(negedge clk);
    wide = 1'b1; vec_src = 64'h7C00_7C00_7C00_7C00; acc_in = '1;
    repeat (2) @(negedge clk);
    chk("R1 idle valid", 128'(out_valid), 128'd0);
    chk("R1 idle hold", acc_out, {64'h1234_5678_9ABC_DEF0, 32'h4000_0000, 32'h3FC0_0000});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule